// File: doc/BRIEF.md
# SEC-DED Memory Word Protector

This block guards 64-bit memory words with eight check bits. The write side is combinational. It takes a data word and returns a 72-bit codeword, ready to store. The check bits come from a parity-check matrix in which every column has odd weight.

The read side takes a stored codeword and forms an 8-bit syndrome. It uses the same matrix, except that the top row covers every stored bit. That row therefore gives the overall parity directly, and no separate parity tree is needed. The read side fixes any single flipped bit and reports any double flip uncorrected. It returns the corrected data and two flags one clock later, through a register stage with an asynchronous active-low reset. The write path and the read path are independent of each other, so a memory controller can encode one word and decode another in the same cycle.

Top module: `secded_mem_ecc`

## Requirements
- R1: The codeword holds the data in bits [63:0] and the check bits in [71:64]. Check bit r is the XOR of the data bits whose column has bit r set. Data column i is the i-th entry of this list: all weight-3 8-bit values in ascending order (56 of them), followed by the lowest eight weight-5 values. The check-bit columns form an identity.
- R2: Reading back an unmodified codeword returns the original data, with both flags low.
- R3: Flipping exactly one data bit of a stored codeword raises the single flag, lowers the double flag, and restores the original data.
- R4: Flipping exactly one check bit raises the single flag, lowers the double flag, and leaves the data output equal to the stored data.
- R5: Any read whose syndrome is nonzero with the top bit (the parity over all 72 bits) at 0 raises the double flag and returns the received data bits unmodified. Every double-bit flip falls in this case.
- R6: Any read with odd overall parity raises exactly one flag. When the low seven syndrome bits match no column, that flag is the double flag and the data is returned unmodified.
- R7: Read results appear on the outputs at the clock edge after the codeword is presented. While reset is low, the data output and both flags are zero.
- R8: The single flag and the double flag are never high together.
- R9: The write codeword follows the write data within the same cycle, whatever is on the read input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the read result register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | 64 | Data word to be encoded |
| wr_code_o | output | 72 | Codeword for storage: check bits over data |
| rd_code_i | input | 72 | Codeword read from storage |
| rd_data_o | output | 64 | Corrected read data, registered |
| rd_single_o | output | 1 | Single-bit error corrected, registered |
| rd_double_o | output | 1 | Uncorrectable error detected, registered |

## Verification
Encoding a new word and decoding an unrelated, corrupted word happen in the same cycle. Every cycle of the bench drives fresh random write data alongside a read codeword that carries a chosen error pattern. The encoder output is compared that cycle against a behavioural encoder. The read outputs are compared one cycle later against a behavioural decoder, whose results pass through a queue. Read patterns cover every single flip at all 72 positions, a sample of double flips, and triple flips that were searched out so that their syndrome matches no column.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int LOC_W  = CHK_W - 1;

  typedef logic [CHK_W-1:0] col_t;

  // Data column idx: odd weights from 3 upward, ascending value within a weight
  function automatic col_t data_col(input int idx);
    int seen;
    seen = 0;
    for (int w = 3; w <= CHK_W; w += 2) begin
      for (int v = 0; v < (1 << CHK_W); v++) begin
        if ($countones(col_t'(v)) == w) begin
          if (seen == idx) return col_t'(v);
          seen++;
        end
      end
    end
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] row_mask(input int row);
    logic [DATA_W-1:0] m;
    col_t c;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c = data_col(i);
      m[i] = c[row];
    end
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc import secded_pkg::*; (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CHK_W-1:0] chk;

  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(r);
    assign chk[r] = ^(data_i & MASK);
  end

  assign code_o = {chk, data_i};
endmodule

// File: rtl/secded_syn.sv
module secded_syn import secded_pkg::*; (
  input  logic [CODE_W-1:0] code_i,
  output logic [CHK_W-1:0]  syn_o
);
  for (genvar r = 0; r < LOC_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(r);
    assign syn_o[r] = ^(code_i[DATA_W-1:0] & MASK) ^ code_i[DATA_W+r];
  end

  // top row all ones on read: overall parity of the stored word
  assign syn_o[CHK_W-1] = ^code_i;
endmodule

// File: rtl/secded_fix.sv
module secded_fix import secded_pkg::*; (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CHK_W-1:0]  syn_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  logic [DATA_W-1:0] hit_d;
  logic [CHK_W-1:0]  hit_c;
  logic [LOC_W-1:0]  loc;
  logic              odd;

  assign loc = syn_i[LOC_W-1:0];
  assign odd = syn_i[CHK_W-1];

  for (genvar i = 0; i < DATA_W; i++) begin : g_dhit
    localparam col_t COL = data_col(i);
    assign hit_d[i] = (loc == COL[LOC_W-1:0]);
  end

  for (genvar k = 0; k < LOC_W; k++) begin : g_chit
    assign hit_c[k] = (loc == (LOC_W'(1) << k));
  end
  assign hit_c[CHK_W-1] = (loc == '0);

  always_comb begin
    single_o = odd & ((|hit_d) | (|hit_c));
    double_o = (|syn_i) & ~single_o;
    data_o   = code_i[DATA_W-1:0] ^ (hit_d & {DATA_W{single_o}});
  end
endmodule

// File: rtl/secded_mem_ecc.sv
module secded_mem_ecc import secded_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] wr_code_o,
  input  logic [CODE_W-1:0] rd_code_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_single_o,
  output logic              rd_double_o
);
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] fix_data;
  logic              fix_single, fix_double;

  secded_enc u_enc (.data_i(wr_data_i), .code_o(wr_code_o));

  secded_syn u_syn (.code_i(rd_code_i), .syn_o(syn));

  secded_fix u_fix (
    .code_i  (rd_code_i),
    .syn_i   (syn),
    .data_o  (fix_data),
    .single_o(fix_single),
    .double_o(fix_double)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o   <= '0;
      rd_single_o <= 1'b0;
      rd_double_o <= 1'b0;
    end else begin
      rd_data_o   <= fix_data;
      rd_single_o <= fix_single;
      rd_double_o <= fix_double;
    end
  end
endmodule

// File: rtl/secded_mem_ecc_chk.sv
module secded_mem_ecc_chk import secded_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [CODE_W-1:0] wr_code_o,
  input logic [CODE_W-1:0] rd_code_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_single_o,
  input logic              rd_double_o
);
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_single_o && rd_double_o)); // R8

  AST_STORED_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_code_i == wr_code_o) |=>
      (!rd_single_o && !rd_double_o && rd_data_o == $past(wr_data_i))); // R2

  AST_SINGLE_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_single_o |-> ($countones(rd_data_o ^ $past(rd_code_i[DATA_W-1:0])) <= 1)); // R3

  AST_DOUBLE_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_double_o |-> (rd_data_o == $past(rd_code_i[DATA_W-1:0]))); // R5

  AST_ODD_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^rd_code_i) |=> (rd_single_o || rd_double_o)); // R6

  AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == '0 && !rd_single_o && !rd_double_o)); // R7
endmodule

bind secded_mem_ecc secded_mem_ecc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_data_i  (wr_data_i),
  .wr_code_o  (wr_code_o),
  .rd_code_i  (rd_code_i),
  .rd_data_o  (rd_data_o),
  .rd_single_o(rd_single_o),
  .rd_double_o(rd_double_o)
);

// File: tb/secded_mem_ecc_bench.sv
`timescale 1ns/1ps
module secded_mem_ecc_bench;
  localparam int DW = 64;
  localparam int CW = 72;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] wr_code;
  logic [CW-1:0] rd_code = '0;
  logic [DW-1:0] rd_data;
  logic          rd_single, rd_double;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [DW-1:0] d;
    logic          s;
    logic          b;
    string         req;
  } exp_t;

  exp_t          q[$];
  logic [7:0]    cols[CW];
  logic [DW-1:0] cur_wd = '0;

  always #2.5 clk = ~clk;

  secded_mem_ecc u_secded_mem_ecc (
    .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data), .wr_code_o(wr_code),
    .rd_code_i(rd_code), .rd_data_o(rd_data), .rd_single_o(rd_single),
    .rd_double_o(rd_double)
  );

  task automatic build_cols();
    int n;
    n = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 0; v < 256; v++)
        if (n < DW && $countones(v[7:0]) == w) begin cols[n] = v[7:0]; n++; end
    for (int k = 0; k < 8; k++) cols[DW+k] = 8'(1 << k);
  endtask

  function automatic logic [CW-1:0] encode(logic [DW-1:0] d);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < DW; i++) if (d[i]) c ^= cols[i];
    return {c, d};
  endfunction

  // behavioural decoder from R2..R6
  function automatic exp_t decode(logic [CW-1:0] c);
    exp_t e;
    logic [7:0] s;
    int pos;
    s = '0;
    for (int p = 0; p < CW; p++) if (c[p]) s[6:0] ^= cols[p][6:0];
    s[7] = ^c;
    e.d = c[DW-1:0]; e.s = 1'b0; e.b = 1'b0; e.req = "R2";
    if (s != 0) begin
      pos = -1;
      if (s[7]) for (int p = 0; p < CW; p++) if (pos < 0 && cols[p][6:0] == s[6:0]) pos = p;
      if (pos >= 0) begin
        e.s = 1'b1;
        if (pos < DW) begin e.d[pos] = ~e.d[pos]; e.req = "R3"; end
        else e.req = "R4";
      end else begin
        e.b = 1'b1;
        e.req = s[7] ? "R6" : "R5";
      end
    end
    return e;
  endfunction

  task automatic chk(string req, string what, logic [CW-1:0] got, logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(logic [DW-1:0] wd, logic [CW-1:0] rc);
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) begin
      e = q.pop_front();
      chk({e.req, "/R7"}, "rd_data", CW'(rd_data), CW'(e.d));
      chk({e.req, "/R7"}, "single", CW'(rd_single), CW'(e.s));
      chk({e.req, "/R7"}, "double", CW'(rd_double), CW'(e.b));
      chk("R8", "flags both", CW'(rd_single & rd_double), '0);
    end
    chk("R1/R9", "wr_code", wr_code, encode(cur_wd));
    wr_data = wd;
    cur_wd  = wd;
    rd_code = rc;
    q.push_back(decode(rc));
  endtask

  function automatic logic [DW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [CW-1:0] cw;
    int tri_i[$], tri_j[$], tri_k[$];
    logic [6:0] x;
    logic hit;
    build_cols();
    rd_code = {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF};
    repeat (3) @(negedge clk);
    chk("R7", "reset data", CW'(rd_data), '0);
    chk("R7", "reset single", CW'(rd_single), '0);
    chk("R7", "reset double", CW'(rd_double), '0);
    rst_n = 1'b1;

    // R2: clean reads, including extremes
    step('0, encode('0));
    step('1, encode('1));
    for (int n = 0; n < 40; n++) begin
      d = rnd64();
      step(rnd64(), encode(d));
    end
    // R9: read the very word being written
    for (int n = 0; n < 8; n++) begin
      d = rnd64();
      step(d, encode(d));
    end

    // R3/R4: every single flip over several words
    for (int w = 0; w < 4; w++) begin
      d = (w == 0) ? '0 : (w == 1) ? '1 : rnd64();
      for (int p = 0; p < CW; p++) begin
        cw = encode(d);
        cw[p] = ~cw[p];
        step(rnd64(), cw);
      end
    end

    // R5: sampled double flips
    for (int n = 0; n < 300; n++) begin
      int a, b;
      d = rnd64();
      a = $urandom_range(CW-1);
      b = (a + 1 + $urandom_range(CW-2)) % CW;
      cw = encode(d);
      cw[a] = ~cw[a];
      cw[b] = ~cw[b];
      step(rnd64(), cw);
    end

    // R6: triple flips whose location matches no column
    for (int i = 0; i < DW && tri_i.size() < 12; i++)
      for (int j = i + 1; j < DW && tri_i.size() < 12; j++)
        for (int k = j + 1; k < DW && tri_i.size() < 12; k++) begin
          x = cols[i][6:0] ^ cols[j][6:0] ^ cols[k][6:0];
          hit = 1'b0;
          for (int p = 0; p < CW; p++) if (cols[p][6:0] == x) hit = 1'b1;
          if (!hit) begin tri_i.push_back(i); tri_j.push_back(j); tri_k.push_back(k); end
        end
    checks++;
    if (tri_i.size() == 0) begin
      errors++;
      $display("FAIL R6 search: got 0 patterns expected >0");
    end
    for (int n = 0; n < tri_i.size(); n++) begin
      d = rnd64();
      cw = encode(d);
      cw[tri_i[n]] = ~cw[tri_i[n]];
      cw[tri_j[n]] = ~cw[tri_j[n]];
      cw[tri_k[n]] = ~cw[tri_k[n]];
      step(rnd64(), cw);
    end
    // R6: random odd-weight corruptions
    for (int n = 0; n < 100; n++) begin
      d = rnd64();
      cw = encode(d);
      for (int f = 0; f < 3; f++) cw[$urandom_range(CW-1)] ^= 1'b1;
      step(rnd64(), cw);
    end

    step('0, encode('0));
    step('0, encode('0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule